// File: doc/BRIEF.md
# Transfer FIFO with Occupancy Flags and DMA Pacing

This block is the single word buffer between a host side (register accesses or a DMA engine) and an external bus engine. It holds 32-bit words, presents the oldest word on its read port at all times, and turns its occupancy into the status information both sides need. That information covers full and empty, room to accept, data present, and "service soon" flags at the quarter and three-quarter marks. It also raises DMA request and DMA panic lines from four programmable thresholds.

The direction input selects which side the DMA lines serve. In the receive direction the host drains the FIFO, so requests depend on how many words are held. In the transmit direction the host fills it, so requests depend on how much space is free. Any push into a full FIFO or pop from an empty one is refused and latched in a sticky error flag until the host clears it. A flush input empties the buffer in one cycle. A high-water mark records the peak occupancy since the last transfer start, for tuning the thresholds.

Top module: `xfer_fifo_stat`

## Requirements
- R1: Words leave in the order they were accepted; while the FIFO holds data, `pop_data` shows the oldest word without a pop. A push and a pop in the same cycle on a FIFO that is neither empty nor full both succeed and leave the count unchanged.
- R2: `level` equals the number of words held (0..32). `full` is 1 at 32 words, `empty` is 1 at 0 words, `has_data` is the inverse of `empty`, and `can_accept` is the inverse of `full`.
- R3: A push while full, or a pop while empty, is refused and leaves the contents and count unchanged. In the same cycle it sets `err` to 1, visible from the next cycle.
- R4: `err` stays 1 until `err_clr` is 1 in a cycle with no new refused access; it then reads 0 from the next cycle. A refused access in the same cycle as `err_clr` keeps `err` at 1.
- R5: When `clear` is 1, the FIFO is empty from the next cycle. A push or pop in that cycle is ignored and raises no error.
- R6: `need_read` is 1 when `level` is greater than 24, or when `xfer_done` is 1 and `level` is not 0.
- R7: `need_write` is 1 when `level` is less than 8.
- R8: `dma_req` is 0 while `dma_en` is 0. With `dma_en` at 1, `dma_req` depends on `dir_tx`. With `dir_tx` at 0 (receive), it is 1 when `level` >= `rd_req_thr`. With `dir_tx` at 1 (transmit), it is 1 when 32 - `level` >= `wr_req_thr`.
- R9: `dma_panic` follows the same rule as R8, with `rd_panic_thr` and `wr_panic_thr` in place of the request thresholds.
- R10: In a cycle with `xfer_start` at 1, `peak` is reloaded with the count that results from that cycle. In any other cycle it becomes the larger of its value and that resulting count. `peak` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Flush the FIFO |
| xfer_start | input | 1 | Transfer begins; restarts the high-water mark |
| xfer_done | input | 1 | Transfer has finished (level) |
| dir_tx | input | 1 | 1 = transmit (host fills), 0 = receive (host drains) |
| dma_en | input | 1 | Enables DMA request and panic outputs |
| rd_req_thr | input | 6 | Receive-direction request threshold (words held) |
| wr_req_thr | input | 6 | Transmit-direction request threshold (words free) |
| rd_panic_thr | input | 6 | Receive-direction panic threshold |
| wr_panic_thr | input | 6 | Transmit-direction panic threshold |
| push | input | 1 | Write one word |
| push_data | input | 32 | Word to write |
| pop | input | 1 | Remove the oldest word |
| err_clr | input | 1 | Clear the sticky error flag |
| pop_data | output | 32 | Oldest word held |
| level | output | 6 | Current occupancy |
| peak | output | 6 | Highest occupancy since the last transfer start |
| full | output | 1 | FIFO holds 32 words |
| empty | output | 1 | FIFO holds no word |
| has_data | output | 1 | At least one word held |
| can_accept | output | 1 | At least one slot free |
| need_read | output | 1 | Above three quarters, or done with data left |
| need_write | output | 1 | Below one quarter |
| err | output | 1 | Sticky refused-access flag |
| dma_req | output | 1 | DMA request |
| dma_panic | output | 1 | DMA panic |

## Verification
Every cycle, the assertions check the following:
- the occupancy never exceeds capacity, and a refused push or pop leaves the count intact and raises the error;
- a flush yields an empty FIFO;
- the error holds until it is cleared, and DMA lines are never raised while DMA is disabled;
- a finished transfer with data left always asks to be read;
- the high-water mark never falls below the live count and only drops at a transfer start.

The exact data ordering, the threshold arithmetic in both directions, and the precedence of a new error over a clear can only be shown by the bench's scenarios. The same holds for the reload value of the mark at a start. For these, a queue-based model is compared on every cycle across directed fills, drains, flushes and a long random run.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
    // Which side of the FIFO the DMA pacing lines serve.
    typedef enum logic {
        DIR_RX = 1'b0,   // host drains: pace on words held
        DIR_TX = 1'b1    // host fills: pace on words free
    } xfer_dir_e;
endpackage

// File: rtl/xfer_fifo_core.sv
module xfer_fifo_core #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    parameter int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              err_clr,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  count_nxt,
    output logic              err
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } core_st_t;

    core_st_t st_q, st_d;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok, bad_acc;

    always_comb begin
        st_d    = st_q;
        push_ok = push && !clear && (st_q.cnt != FULL_CNT);
        pop_ok  = pop  && !clear && (st_q.cnt != '0);
        bad_acc = !clear && ((push && st_q.cnt == FULL_CNT) || (pop && st_q.cnt == '0));
        if (clear) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_ok) st_d.wp = st_q.wp + PTR_W'(1);
            if (pop_ok)  st_d.rp = st_q.rp + PTR_W'(1);
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
                2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
        if (bad_acc)      st_d.err = 1'b1;
        else if (err_clr) st_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= push_data;
    end

    assign pop_data  = mem_q[st_q.rp];
    assign count     = st_q.cnt;
    assign count_nxt = st_d.cnt;
    assign err       = st_q.err;

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    a_r3_push_full_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clear && count == FULL_CNT) |=> (count == FULL_CNT && err));
    a_r3_pop_empty_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clear && count == '0) |=> (count == '0 && err));
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count == '0);
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);
endmodule

// File: rtl/xfer_fifo_thresh.sv
module xfer_fifo_thresh
    import xfer_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [CNT_W-1:0] count,
    input  logic             xfer_done,
    input  logic             dir_tx,
    input  logic             dma_en,
    input  logic [CNT_W-1:0] rd_req_thr,
    input  logic [CNT_W-1:0] wr_req_thr,
    input  logic [CNT_W-1:0] rd_panic_thr,
    input  logic [CNT_W-1:0] wr_panic_thr,
    output logic             full,
    output logic             empty,
    output logic             need_read,
    output logic             need_write,
    output logic             dma_req,
    output logic             dma_panic
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HI_MARK  = CNT_W'((3 * DEPTH) / 4);
    localparam logic [CNT_W-1:0] LO_MARK  = CNT_W'(DEPTH / 4);

    logic [CNT_W-1:0] free_d;
    logic             tx_d;

    always_comb begin
        free_d     = FULL_CNT - count;
        tx_d       = (xfer_dir_e'(dir_tx) == DIR_TX);
        full       = (count == FULL_CNT);
        empty      = (count == '0);
        need_read  = (count > HI_MARK) || (xfer_done && !empty);
        need_write = (count < LO_MARK);
        dma_req    = dma_en && (tx_d ? (free_d >= wr_req_thr) : (count >= rd_req_thr));
        dma_panic  = dma_en && (tx_d ? (free_d >= wr_panic_thr) : (count >= rd_panic_thr));
    end
endmodule

// File: rtl/xfer_fifo_peak.sv
module xfer_fifo_peak #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] count_nxt,
    output logic [CNT_W-1:0] peak
);
    logic [CNT_W-1:0] peak_q, peak_d;

    always_comb begin
        if (xfer_start)             peak_d = count_nxt;
        else if (count_nxt > peak_q) peak_d = count_nxt;
        else                        peak_d = peak_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) peak_q <= '0;
        else        peak_q <= peak_d;
    end

    assign peak = peak_q;

    a_r10_peak_covers_count: assert property (@(posedge clk) disable iff (!rst_n)
        peak_q >= count);
    a_r10_peak_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_start |=> peak_q >= $past(peak_q));
endmodule

// File: rtl/xfer_fifo_stat.sv
module xfer_fifo_stat #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    parameter int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              xfer_start,
    input  logic              xfer_done,
    input  logic              dir_tx,
    input  logic              dma_en,
    input  logic [CNT_W-1:0]  rd_req_thr,
    input  logic [CNT_W-1:0]  wr_req_thr,
    input  logic [CNT_W-1:0]  rd_panic_thr,
    input  logic [CNT_W-1:0]  wr_panic_thr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              err_clr,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  level,
    output logic [CNT_W-1:0]  peak,
    output logic              full,
    output logic              empty,
    output logic              has_data,
    output logic              can_accept,
    output logic              need_read,
    output logic              need_write,
    output logic              err,
    output logic              dma_req,
    output logic              dma_panic
);
    logic [CNT_W-1:0] cnt_nxt;

    xfer_fifo_core #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .push(push), .push_data(push_data), .pop(pop), .err_clr(err_clr),
        .pop_data(pop_data), .count(level), .count_nxt(cnt_nxt), .err(err)
    );

    xfer_fifo_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_thresh (
        .count(level), .xfer_done(xfer_done), .dir_tx(dir_tx), .dma_en(dma_en),
        .rd_req_thr(rd_req_thr), .wr_req_thr(wr_req_thr),
        .rd_panic_thr(rd_panic_thr), .wr_panic_thr(wr_panic_thr),
        .full(full), .empty(empty), .need_read(need_read), .need_write(need_write),
        .dma_req(dma_req), .dma_panic(dma_panic)
    );

    xfer_fifo_peak #(.CNT_W(CNT_W)) u_peak (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
        .count(level), .count_nxt(cnt_nxt), .peak(peak)
    );

    assign has_data   = !empty;
    assign can_accept = !full;

    a_r8_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> (!dma_req && !dma_panic));
    a_r2_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    a_r6_done_leftover: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && has_data) |-> need_read);
endmodule

// File: tb/xfer_fifo_stat_tb.sv
module xfer_fifo_stat_tb;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 0, xfer_start = 0, xfer_done = 0, dir_tx = 0, dma_en = 0;
    logic [5:0]  rd_req_thr = 0, wr_req_thr = 0, rd_panic_thr = 0, wr_panic_thr = 0;
    logic        push = 0, pop = 0, err_clr = 0;
    logic [31:0] push_data = 0;
    logic [31:0] pop_data;
    logic [5:0]  level, peak;
    logic        full, empty, has_data, can_accept, need_read, need_write, err, dma_req, dma_panic;

    always #5 clk = ~clk;

    xfer_fifo_stat u_dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .xfer_start(xfer_start),
        .xfer_done(xfer_done), .dir_tx(dir_tx), .dma_en(dma_en),
        .rd_req_thr(rd_req_thr), .wr_req_thr(wr_req_thr),
        .rd_panic_thr(rd_panic_thr), .wr_panic_thr(wr_panic_thr),
        .push(push), .push_data(push_data), .pop(pop), .err_clr(err_clr),
        .pop_data(pop_data), .level(level), .peak(peak), .full(full), .empty(empty),
        .has_data(has_data), .can_accept(can_accept), .need_read(need_read),
        .need_write(need_write), .err(err), .dma_req(dma_req), .dma_panic(dma_panic)
    );

    int          n_cmp = 0, n_bad = 0;
    logic [31:0] mq[$];
    bit          m_err = 0;
    int          m_peak = 0;

    task automatic cmp(string req, string nm, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic check_all();
        int  sz = mq.size();
        int  fr = DEPTH - sz;
        bit  e_req, e_pan;
        e_req = dma_en && (dir_tx ? (fr >= int'(wr_req_thr)) : (sz >= int'(rd_req_thr)));
        e_pan = dma_en && (dir_tx ? (fr >= int'(wr_panic_thr)) : (sz >= int'(rd_panic_thr)));
        cmp("R2", "level", level, sz);
        cmp("R2", "full", full, sz == DEPTH);
        cmp("R2", "empty", empty, sz == 0);
        cmp("R2", "has_data", has_data, sz != 0);
        cmp("R2", "can_accept", can_accept, sz != DEPTH);
        if (sz > 0) cmp("R1", "pop_data", pop_data, mq[0]);
        cmp("R6", "need_read", need_read, (sz > 24) || (xfer_done && sz != 0));
        cmp("R7", "need_write", need_write, sz < 8);
        cmp("R4", "err", err, m_err);
        cmp("R8", "dma_req", dma_req, e_req);
        cmp("R9", "dma_panic", dma_panic, e_pan);
        cmp("R10", "peak", peak, m_peak);
    endtask

    // One clock: compare, take the edge, advance the model, drop pulses.
    task automatic cycle();
        int  sz;
        bit  ev;
        #1;
        check_all();
        @(posedge clk);
        sz = mq.size();
        ev = !clear && ((push && sz == DEPTH) || (pop && sz == 0));
        if (clear) mq.delete();
        else begin
            if (pop && sz > 0) void'(mq.pop_front());
            if (push && sz < DEPTH) mq.push_back(push_data);
        end
        if (ev) m_err = 1;
        else if (err_clr) m_err = 0;
        if (xfer_start) m_peak = mq.size();
        else if (mq.size() > m_peak) m_peak = mq.size();
        @(negedge clk);
        push = 0; pop = 0; clear = 0; xfer_start = 0; err_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        #1 check_all();                 // reset state
        @(negedge clk);
        rst_n = 1;
        rd_req_thr = 4; wr_req_thr = 10; rd_panic_thr = 20; wr_panic_thr = 28;
        dma_en = 1; dir_tx = 0;

        // R10: start of a receive transfer, then fill to capacity (R1, R2, R6, R8, R9)
        xfer_start = 1; cycle();
        for (int i = 0; i < DEPTH; i++) begin
            push = 1; push_data = 32'hA500_0000 + i; cycle();
        end
        // R3: push while full is refused
        push = 1; push_data = 32'hDEAD_BEEF; cycle();
        #1 cmp("R3", "level_after_refused_push", level, DEPTH);
        cmp("R3", "err_after_refused_push", err, 1);
        cmp("R1", "head_after_refused_push", pop_data, 32'hA500_0000);
        @(negedge clk);
        // R4: refused access wins over clear, then clear alone works
        push = 1; err_clr = 1; cycle();
        err_clr = 1; cycle();
        #1 cmp("R4", "err_cleared", err, 0);
        @(negedge clk);

        // R6: transfer done with data left; switch to transmit direction
        xfer_done = 1; dir_tx = 1;
        for (int i = 0; i < 20; i++) begin pop = 1; cycle(); end
        // R1: simultaneous push/pop in the middle
        for (int i = 0; i < 5; i++) begin
            push = 1; pop = 1; push_data = 32'h5A00_0000 + i; cycle();
        end
        for (int i = 0; i < 12; i++) begin pop = 1; cycle(); end
        // R3: pop while empty, then push+pop on empty
        pop = 1; cycle();
        push = 1; pop = 1; push_data = 32'h1234_5678; cycle();
        #1 cmp("R3", "level_push_pop_empty", level, 1);
        @(negedge clk);
        xfer_done = 0; err_clr = 1; cycle();

        // R5: clear with push and pop asserted
        for (int i = 0; i < 10; i++) begin push = 1; push_data = i; cycle(); end
        clear = 1; push = 1; pop = 1; cycle();
        #1 cmp("R5", "level_after_clear", level, 0);
        cmp("R5", "no_err_on_clear", err, 0);
        @(negedge clk);

        // R8/R9: DMA disabled
        dma_en = 0;
        for (int i = 0; i < 6; i++) begin push = 1; push_data = ~i; cycle(); end
        dma_en = 1;

        // Random run over all inputs
        for (int i = 0; i < 3000; i++) begin
            push       = ($urandom % 100) < 55;
            pop        = ($urandom % 100) < 45;
            push_data  = $urandom;
            clear      = ($urandom % 200) == 0;
            xfer_start = ($urandom % 64) == 0;
            err_clr    = ($urandom % 16) == 0;
            if (($urandom % 50) == 0) begin
                xfer_done    = $urandom;
                dir_tx       = $urandom;
                dma_en       = ($urandom % 4) != 0;
                rd_req_thr   = 6'($urandom % 34);
                wr_req_thr   = 6'($urandom % 34);
                rd_panic_thr = 6'($urandom % 34);
                wr_panic_thr = 6'($urandom % 34);
            end
            cycle();
        end

        #1 check_all();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule